// File: doc/BRIEF.md
# Comparator Calibration Sequencer

This block steps a bank of threshold comparators through calibration, one comparator at a time. The bank has `2^IDX_W - 1` comparators arranged as a binary search tree, and a single trim counter is shared by all of them. A slot index counts upward from 0. The scheduler decodes the index into a one-hot clock enable for the comparator being trimmed. It also turns the index into the matching threshold code for a reference DAC, and tells the shared trim counter which way to count.

Each index owns a fixed slot. The first `2^TRIM_W` cycles of a slot are trim cycles. The last cycle clears the shared trim counter so that the next comparator starts from a known code. Comparators are numbered in tree order: the root is index 1, and the children of node k are 2k and 2k+1. Counting the index upward therefore calibrates the tree one level at a time, starting at the root and ending at the leaves.

Index 0 names no comparator. It still takes a slot, and that slot ends with a clear, so the trim counter is reset before the root is calibrated. While a run is in progress the coarse sign stage is held in bypass. When the last slot ends, bypass drops and a done flag is raised.

Top module: `cal_scheduler`

## Requirements
- R1: After a synchronous active-low reset, with defaults (IDX_W=7, TRIM_W=5): `cal_sel` is all zero, `trim_clr`, `coarse_bypass` and `cal_done` are 0, `dac_code` is 0 and `trim_up` is 1 (index at rest is 0).
- R2: A `cal_start` seen while a run is in progress is ignored. The run continues without any change to its sequence or length.
- R3: Every slot lasts exactly 33 cycles. In cycles 0..31 of a slot `trim_clr` is 0. In cycle 32 `trim_clr` is 1 and `cal_sel` is all zero.
- R4: The index starts at 0 in the cycle after `cal_start` is taken, and advances by one per slot through 0..127. The slot for index 0 drives no select bit.
- R5: During trim cycles of index k (k ≥ 1), exactly bit k of `cal_sel` is 1. At every other time `cal_sel` is all zero.
- R6: `dac_code` is offset binary, with 64 meaning a zero threshold. For index k at tree depth d = floor(log2 k) and position p = k − 2^d, the code is (2p+1)·2^(6−d). For k = 0 the code is 0. The code is steady for a whole slot.
- R7: `trim_up` is the inverse of the index LSB: 1 (count up) for even indices and 0 (count down) for odd ones.
- R8: `coarse_bypass` is 1 for exactly the 4224 cycles of a run and 0 at all other times.
- R9: In the cycle after the clear cycle of index 127, `cal_done` becomes 1 and `coarse_bypass` becomes 0. The index returns to 0. `cal_done` holds until the next start.
- R10: A `cal_start` taken while `cal_done` is 1 clears `cal_done` and begins a new, identical run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Begin a calibration run when idle or done |
| cal_sel | output | 128 | One-hot clock enable for the comparator being trimmed |
| dac_code | output | 7 | Threshold code for the reference DAC |
| trim_up | output | 1 | Shared trim counter direction: 1 up, 0 down |
| trim_clr | output | 1 | Clears the shared trim counter |
| coarse_bypass | output | 1 | Bypass the coarse sign stage during a run |
| cal_done | output | 1 | All slots finished |

## Verification
The assertions check the cycle-local rules on every cycle:
- the select is at most one-hot;
- no select is active in a clear cycle;
- a select is only ever active under bypass;
- the DAC code holds steady within a slot;
- a start is ignored mid-run;
- the finish hand-off (done raised, bypass dropped) happens right after the last slot.

Only the bench's scenarios can show the whole-run behaviour:
- the full index order and the threshold code of every node;
- the exact 4224-cycle length of a run;
- a start landing in the very last cycle of a run;
- a clean restart from the done state.

// File: rtl/cal_sched_pkg.sv
// Package: shared types for the calibration sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package cal_sched_pkg;

    // Sequencer phase.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/cal_slot_timer.sv
// Module: cal_slot_timer
// Counts the cycles of one slot: 2^TRIM_W trim cycles followed by one
// clear cycle. Flags the trim phase and the final cycle of the slot.
// Assumes: restart_i has priority over run_i; the counter holds when idle.
module cal_slot_timer #(
    parameter int TRIM_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic trim_phase_o,
    output logic slot_last_o
);
    localparam int TRIM_CYC = 1 << TRIM_W;
    localparam int SLOT_LEN = TRIM_CYC + 1;
    localparam int CNT_W    = $clog2(SLOT_LEN);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(SLOT_LEN - 1);
    localparam logic [CNT_W-1:0] TRIM_VAL = CNT_W'(TRIM_CYC);

    logic [CNT_W-1:0] slot_q;

    // Slot cycle counter: wraps at the end of each slot while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (restart_i) begin
            slot_q <= '0;
        end else if (run_i) begin
            slot_q <= (slot_q == LAST_VAL) ? '0 : slot_q + 1'b1;
        end
    end

    assign trim_phase_o = run_i && (slot_q < TRIM_VAL);
    assign slot_last_o  = run_i && (slot_q == LAST_VAL);

    // R3: the counter never passes the clear cycle.
    p_slot_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= LAST_VAL);

    // R3: a running slot steps by one or wraps from its last cycle.
    p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && !slot_last_o) |=> (slot_q == $past(slot_q) + 1'b1));

endmodule

// File: rtl/cal_index_ctr.sv
// Module: cal_index_ctr
// Holds the slot index, which is the tree-ordered comparator number.
// Advances by one per slot and wraps back to 0 after the last slot.
// Assumes: advance_i pulses once, in the clear cycle of each slot.
module cal_index_ctr #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             advance_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             idx_last_o
);
    // Index register: cleared on start, stepped at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (restart_i) begin
            idx_o <= '0;
        end else if (advance_i) begin
            idx_o <= idx_o + 1'b1;
        end
    end

    assign idx_last_o = &idx_o;

    // R4: an advance moves the index to the next comparator.
    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !restart_i) |=> (idx_o == $past(idx_o) + 1'b1));

    // R4: without an advance or a restart the index holds.
    p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance_i && !restart_i) |=> $stable(idx_o));

endmodule

// File: rtl/cal_thresh_map.sv
// Module: cal_thresh_map
// Turns a tree-ordered comparator number into the reference DAC code of
// its threshold: depth d from the top set bit, position p below it,
// code = (2p+1) << (IDX_W-1-d), offset binary with mid-scale as zero.
// Assumes: index 0 maps to code 0 (no comparator).
module cal_thresh_map #(
    parameter int IDX_W = 7
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] code_o
);
    localparam int DEP_W = (IDX_W > 1) ? $clog2(IDX_W) : 1;

    logic [DEP_W-1:0] depth;
    logic [DEP_W-1:0] shamt;
    logic [IDX_W-1:0] pos;
    logic [IDX_W:0]   wide;

    // Find the tree depth from the highest set bit of the index.
    always_comb begin
        depth = '0;
        for (int d = 0; d < IDX_W; d++) begin
            if (idx_i[d]) depth = DEP_W'(d);
        end
    end

    // Strip the leading bit to get the position, then place 2p+1.
    always_comb begin
        pos   = idx_i ^ (IDX_W'(1) << depth);
        shamt = DEP_W'(IDX_W - 1) - depth;
        wide  = {pos, 1'b1} << shamt;
        code_o = (idx_i == '0) ? '0 : wide[IDX_W-1:0];
    end

endmodule

// File: rtl/cal_sel_decode.sv
// Module: cal_sel_decode
// One-hot clock-enable decode of the comparator index. Line 0 exists for
// alignment only and is never driven high (index 0 has no comparator).
// Assumes: en_i is high only during trim cycles.
module cal_sel_decode #(
    parameter int IDX_W = 7,
    parameter int NSEL  = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             en_i,
    output logic [NSEL-1:0]  sel_o
);
    assign sel_o[0] = 1'b0;

    // One enable line per comparator, active for its own index only.
    for (genvar k = 1; k < NSEL; k++) begin : g_line
        assign sel_o[k] = en_i && (idx_i == IDX_W'(k));
    end

endmodule

// File: rtl/cal_scheduler.sv
// Module: cal_scheduler (top)
// Sequences calibration of every comparator in tree order, one fixed
// slot each, with a shared trim counter cleared at the end of each slot.
// Drives the select, DAC code, trim direction, trim clear, coarse bypass
// and the done flag.
// Assumes: cal_start is honoured only when idle or done.
module cal_scheduler #(
    parameter int IDX_W  = 7,
    parameter int TRIM_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cal_start,
    output logic [(1<<IDX_W)-1:0]   cal_sel,
    output logic [IDX_W-1:0]        dac_code,
    output logic                    trim_up,
    output logic                    trim_clr,
    output logic                    coarse_bypass,
    output logic                    cal_done
);
    import cal_sched_pkg::*;

    localparam int NSEL = 1 << IDX_W;

    seq_state_t       st_q;
    seq_state_t       st_d;
    logic             running;
    logic             take_start;
    logic             trim_phase;
    logic             slot_last;
    logic             idx_last;
    logic             run_end;
    logic [IDX_W-1:0] idx;

    assign running    = (st_q == SEQ_RUN);
    assign take_start = cal_start && !running;
    assign run_end    = slot_last && idx_last;

    // Next phase: start from idle or done, finish after the last slot.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE: if (cal_start) st_d = SEQ_RUN;
            SEQ_RUN:  if (run_end)   st_d = SEQ_DONE;
            SEQ_DONE: if (cal_start) st_d = SEQ_RUN;
            default:  st_d = SEQ_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    cal_slot_timer #(.TRIM_W(TRIM_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (take_start),
        .run_i        (running),
        .trim_phase_o (trim_phase),
        .slot_last_o  (slot_last)
    );

    cal_index_ctr #(.IDX_W(IDX_W)) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (take_start),
        .advance_i  (slot_last),
        .idx_o      (idx),
        .idx_last_o (idx_last)
    );

    cal_thresh_map #(.IDX_W(IDX_W)) u_map (
        .idx_i  (idx),
        .code_o (dac_code)
    );

    cal_sel_decode #(.IDX_W(IDX_W), .NSEL(NSEL)) u_decode (
        .idx_i (idx),
        .en_i  (trim_phase),
        .sel_o (cal_sel)
    );

    assign trim_up       = ~idx[0];
    assign trim_clr      = slot_last;
    assign coarse_bypass = running;
    assign cal_done      = (st_q == SEQ_DONE);

    // R5: at most one comparator is enabled at a time.
    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cal_sel));

    // R3: no comparator is enabled during the clear cycle.
    p_clr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trim_clr |-> (cal_sel == '0));

    // R8: a select only appears while the coarse stage is bypassed.
    p_sel_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_sel != '0) |-> coarse_bypass);

    // R6: the DAC code holds for the whole slot.
    p_dac_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_bypass && !trim_clr) |=> $stable(dac_code));

    // R7: the root (odd index) trims downward, its left child upward.
    p_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_sel[1] |-> !trim_up) and (cal_sel[2] |-> trim_up));

    // R2: a start inside a run does not end or restart it.
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cal_start && !run_end) |=> (coarse_bypass && !cal_done));

    // R9: after the last clear cycle the run hands over to done.
    p_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_end) |=> (cal_done && !coarse_bypass && dac_code == '0));

endmodule

// File: tb/cal_scheduler_bench.sv
// Scoreboard bench: the driver computes the expected outputs of the next
// cycle from the requirements and queues them stamped with that cycle;
// the monitor pops and compares at the falling edge.
module cal_scheduler_bench;
    localparam int IDX_W   = 7;
    localparam int NSEL    = 128;
    localparam int SLOT    = 33;
    localparam int RUN_LEN = 4224;

    typedef struct {
        int              cyc;
        logic [NSEL-1:0] sel;
        logic [6:0]      dac;
        logic            up;
        logic            clr;
        logic            byp;
        logic            done;
        string           ctx;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cal_start = 1'b0;
    logic [NSEL-1:0] cal_sel;
    logic [6:0]      dac_code;
    logic            trim_up, trim_clr, coarse_bypass, cal_done;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    // Model state.
    bit m_run = 1'b0;
    int m_n = 0;
    bit m_done = 1'b0;

    cal_scheduler #(.IDX_W(IDX_W), .TRIM_W(5)) u_cal_scheduler (
        .clk           (clk),
        .rst_n         (rst_n),
        .cal_start     (cal_start),
        .cal_sel       (cal_sel),
        .dac_code      (dac_code),
        .trim_up       (trim_up),
        .trim_clr      (trim_clr),
        .coarse_bypass (coarse_bypass),
        .cal_done      (cal_done)
    );

    always #4 clk = ~clk;

    always @(negedge clk) cyc <= cyc + 1;

    // R6 formula: depth from the top set bit, odd position scaled.
    function automatic logic [6:0] thr_code(input int k);
        int d;
        int p;
        if (k == 0) return 7'd0;
        d = 0;
        while ((2 << d) <= k) d++;
        p = k - (1 << d);
        return 7'((2 * p + 1) << (6 - d));
    endfunction

    task automatic check(input bit ok, input string req, input string ctx,
                         input logic [NSEL-1:0] act, input logic [NSEL-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (%s) cyc %0d: actual %h expected %h", req, ctx, cyc, act, exp);
        end
    endtask

    // Drive one cycle and queue the outputs expected after the next edge.
    task automatic drive(input bit st, input bit rst, input string ctx);
        exp_t e;
        int   k;
        int   ph;
        @(negedge clk);
        #2;
        cal_start = st;
        rst_n = ~rst;
        if (rst) begin
            m_run = 0; m_n = 0; m_done = 0;
        end else if (!m_run && st) begin
            m_run = 1; m_n = 0; m_done = 0;
        end else if (m_run) begin
            if (m_n == RUN_LEN - 1) begin
                m_run = 0; m_done = 1;
            end else begin
                m_n++;
            end
        end
        k  = m_run ? m_n / SLOT : 0;
        ph = m_n % SLOT;
        e.cyc  = cyc + 1;
        e.sel  = '0;
        if (m_run && ph < SLOT - 1 && k != 0) e.sel[k] = 1'b1;  // R4, R5
        e.dac  = thr_code(k);
        e.up   = (k % 2 == 0);
        e.clr  = m_run && (ph == SLOT - 1);
        e.byp  = m_run;
        e.done = m_done;
        e.ctx  = ctx;
        q.push_back(e);
    endtask

    // Monitor: compare the stamped expectation for this cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0 && q[0].cyc == cyc) begin
                exp_t e;
                e = q.pop_front();
                check(cal_sel === e.sel, "R5", e.ctx, cal_sel, e.sel);
                check(dac_code === e.dac, "R6", e.ctx, NSEL'(dac_code), NSEL'(e.dac));
                check(trim_up === e.up, "R7", e.ctx, NSEL'(trim_up), NSEL'(e.up));
                check(trim_clr === e.clr, "R3", e.ctx, NSEL'(trim_clr), NSEL'(e.clr));
                check(coarse_bypass === e.byp, "R8", e.ctx, NSEL'(coarse_bypass), NSEL'(e.byp));
                check(cal_done === e.done, "R9", e.ctx, NSEL'(cal_done), NSEL'(e.done));
            end
        end
    end

    // Stimulus.
    initial begin
        for (int i = 0; i < 4; i++) drive(0, 1, "R1 reset");
        for (int i = 0; i < 3; i++) drive(0, 0, "R1 idle");
        drive(1, 0, "R4 first run");
        for (int i = 0; i < 100; i++) drive(0, 0, "R4 first run");
        drive(1, 0, "R2 start mid-run");
        while (!(m_run && m_n == RUN_LEN - 1)) drive(0, 0, "R4 first run");
        drive(1, 0, "R2 start on last cycle");
        for (int i = 0; i < 6; i++) drive(0, 0, "R9 done hold");
        drive(1, 0, "R10 restart");
        while (m_run) drive(0, 0, "R10 second run");
        for (int i = 0; i < 6; i++) drive(0, 0, "R9 done again");
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule